// File: doc/BRIEF.md
# Remappable CPU Address Window Decoder

This block turns a 36-bit CPU physical address into a routing decision. Software programs up to twenty device windows through a 32-bit register port. Each window has a control word and a base word. The control word holds the enable bit, a 4-bit target, an 8-bit attribute and the window size minus one, counted in 64 KiB units. The base word places the window anywhere in the 36-bit space. The lowest-numbered windows also carry a translation pair. With it, an access that lands in such a window can leave the decoder at a different physical address.

Lookups use a valid/ready stream. An address is taken in when `lk_valid` and `lk_ready` are both high. Exactly one cycle later the registered result appears with `res_valid` set. The result stays on the outputs, unchanged, until a cycle in which `res_ready` is high. `lk_ready` is high whenever the result stage is empty or is being drained in the same cycle. This makes back-pressure lossless and still allows one lookup per cycle. The register port has no handshake: a write takes effect at the clock edge in which `reg_we` is high, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `xlat_window_map`

## Requirements
- R1: Control word fields: bit 0 enables the window, bits 7:4 are the target and bits 15:8 are the attribute. Both target and attribute are reported on a hit. Bits 31:16 hold the size minus one in 64 KiB units, so the size is {bits 31:16, 16'hFFFF} + 1.
- R2: Base word: bits 31:16 supply address bits 31:16 and bits 3:0 supply address bits 35:32. The low 16 address bits of the base are zero. An address hits a window when base <= address < base + size. This holds up to the very top of the 36-bit space.
- R3: A window whose enable bit is clear never hits, whatever its other fields hold.
- R4: When several enabled windows contain the address, the window with the lowest index is reported.
- R5: On a miss, `res_hit` is 0 and `res_miss` is 1. Window index, target, attribute and output address are all zero.
- R6: Windows 0 to 7 translate addresses. The output is {remap-high bits 3:0, remap-low bits 31:16, 16'h0} plus (address − base). Windows 8 to 19 pass the address through unchanged. A translating window whose remap pair equals its base also returns the input address.
- R7: Register layout (byte offsets, bits 1:0 ignored). Window w < 8 sits at w*16 and holds control, base, remap low and remap high at +0, +4, +8 and +12. Window w >= 8 sits at 0x90 + (w−8)*8 and holds control at +0 and base at +4.
- R8: Offsets 0x80 to 0x8F, and offsets at or above 0xF0, belong to no register. They read as zero, and writes to them change no register.
- R9: After reset every register reads zero, no window hits, `res_valid` is 0 and `lk_ready` is 1.
- R10: A lookup accepted at one edge gives its result with `res_valid` high after the next edge. While `res_valid` is high and `res_ready` is low, the result is held stable and `lk_ready` is low.
- R11: Writing zero to a window's control word, base word and (where present) remap registers removes the window. Lookups it used to claim go to the next matching window or miss, and its registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Decoder can take a lookup |
| lk_addr | input | 36 | CPU physical address to decode |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Address fell in an enabled window |
| res_miss | output | 1 | Address matched no window |
| res_win | output | 5 | Index of the winning window |
| res_target | output | 4 | Target of the winning window |
| res_attr | output | 8 | Attribute of the winning window |
| res_addr | output | 36 | Translated output address |

## Verification
Some properties are checked on every cycle. Every accepted lookup yields a result on the next cycle. A stalled result neither moves nor lets a new address in. Hit and miss are always exclusive. A miss always carries zero fields. The reserved hole always reads zero. The bench scenarios are needed for the rest: field decoding, the bounds of each window including the top of the address space, priority between overlapping windows, translation arithmetic, the split register layout, the effect of disabled and cleared windows, and the reset contents.

// File: rtl/xwm_pkg.sv
package xwm_pkg;
  localparam int PA_W   = 36;
  localparam int WORD_W = 32;
  localparam int GRAN_W = 16;

  typedef struct packed {
    logic              en;
    logic [3:0]        tgt;
    logic [7:0]        attr;
    logic [PA_W-1:0]   base;
    logic [PA_W:0]     lim;
    logic [PA_W-1:0]   xbase;
    logic              xlat;
  } win_view_t;

  typedef struct packed {
    logic              hit;
    logic [3:0]        tgt;
    logic [7:0]        attr;
    logic [PA_W-1:0]   oaddr;
  } look_res_t;
endpackage

// File: rtl/xwm_regfile.sv
module xwm_regfile
  import xwm_pkg::*;
#(
  parameter int NUM_WIN    = 20,
  parameter int NUM_XLAT   = 8,
  parameter int HOLE_BYTES = 16,
  parameter int REG_AW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [REG_AW-1:0]        addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata,
  output win_view_t [NUM_WIN-1:0]  view
);
  localparam int LO_STRIDE = 16;
  localparam int HI_STRIDE = 8;
  localparam int LO_SPAN   = NUM_XLAT * LO_STRIDE;
  localparam int HI_BASE   = LO_SPAN + HOLE_BYTES;
  localparam int WA_W      = REG_AW - 2;

  function automatic int win_word(input int w);
    if (w < NUM_XLAT) return (w * LO_STRIDE) / 4;
    else              return (HI_BASE + (w - NUM_XLAT) * HI_STRIDE) / 4;
  endfunction

  logic [WA_W-1:0] wa;
  assign wa = addr[REG_AW-1:2];

  logic [WORD_W-1:0] ctrl_q [NUM_WIN];
  logic [WORD_W-1:0] base_q [NUM_WIN];
  logic [WORD_W-1:0] rlo_q  [NUM_WIN];
  logic [WORD_W-1:0] rhi_q  [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int WW = win_word(w);
    localparam bit XL = (w < NUM_XLAT);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[w] <= '0;
        base_q[w] <= '0;
      end else if (we) begin
        if (wa == WA_W'(WW))     ctrl_q[w] <= wdata;
        if (wa == WA_W'(WW + 1)) base_q[w] <= wdata;
      end
    end

    if (XL) begin : g_xl
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rlo_q[w] <= '0;
          rhi_q[w] <= '0;
        end else if (we) begin
          if (wa == WA_W'(WW + 2)) rlo_q[w] <= wdata;
          if (wa == WA_W'(WW + 3)) rhi_q[w] <= wdata;
        end
      end
    end else begin : g_pass
      assign rlo_q[w] = '0;
      assign rhi_q[w] = '0;
    end

    logic [PA_W-1:0] base_full;
    logic [PA_W:0]   size_full;
    assign base_full = {base_q[w][3:0], base_q[w][31:16], {GRAN_W{1'b0}}};
    assign size_full = {5'b0, ctrl_q[w][31:16], {GRAN_W{1'b1}}} + (PA_W+1)'(1);

    assign view[w].en    = ctrl_q[w][0];
    assign view[w].tgt   = ctrl_q[w][7:4];
    assign view[w].attr  = ctrl_q[w][15:8];
    assign view[w].base  = base_full;
    assign view[w].lim   = {1'b0, base_full} + size_full;
    assign view[w].xbase = {rhi_q[w][3:0], rlo_q[w][31:16], {GRAN_W{1'b0}}};
    assign view[w].xlat  = XL;
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (wa == WA_W'(win_word(w)))     rdata = ctrl_q[w];
      if (wa == WA_W'(win_word(w) + 1)) rdata = base_q[w];
      if (w < NUM_XLAT) begin
        if (wa == WA_W'(win_word(w) + 2)) rdata = rlo_q[w];
        if (wa == WA_W'(win_word(w) + 3)) rdata = rhi_q[w];
      end
    end
  end
endmodule

// File: rtl/xwm_match.sv
module xwm_match
  import xwm_pkg::*;
#(
  parameter int NUM_WIN = 20,
  parameter int WIN_W   = 5
) (
  input  logic [PA_W-1:0]          addr,
  input  win_view_t [NUM_WIN-1:0]  view,
  output look_res_t                res,
  output logic [WIN_W-1:0]         idx
);
  logic [NUM_WIN-1:0] inwin;
  logic [PA_W-1:0]    xaddr [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [PA_W:0] a_ext;
    assign a_ext    = {1'b0, addr};
    assign inwin[w] = view[w].en && (a_ext >= {1'b0, view[w].base}) &&
                      (a_ext < view[w].lim);
    assign xaddr[w] = view[w].xlat ? (view[w].xbase + (addr - view[w].base)) : addr;
  end

  always_comb begin
    res = '0;
    idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (inwin[w]) begin
        res.hit   = 1'b1;
        res.tgt   = view[w].tgt;
        res.attr  = view[w].attr;
        res.oaddr = xaddr[w];
        idx       = WIN_W'(w);
      end
    end
  end
endmodule

// File: rtl/xlat_window_map.sv
module xlat_window_map
  import xwm_pkg::*;
#(
  parameter int NUM_WIN    = 20,
  parameter int NUM_XLAT   = 8,
  parameter int HOLE_BYTES = 16,
  parameter int REG_AW     = 8,
  localparam int WIN_W     = $clog2(NUM_WIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [35:0]         lk_addr,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                res_hit,
  output logic                res_miss,
  output logic [WIN_W-1:0]    res_win,
  output logic [3:0]          res_target,
  output logic [7:0]          res_attr,
  output logic [35:0]         res_addr
);
  win_view_t [NUM_WIN-1:0] view;
  look_res_t               nxt;
  logic [WIN_W-1:0]        nxt_idx;
  logic                    take;

  xwm_regfile #(
    .NUM_WIN(NUM_WIN), .NUM_XLAT(NUM_XLAT),
    .HOLE_BYTES(HOLE_BYTES), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .view(view)
  );

  xwm_match #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_match (
    .addr(lk_addr), .view(view), .res(nxt), .idx(nxt_idx)
  );

  assign lk_ready = !res_valid || res_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
      res_win    <= '0;
      res_target <= '0;
      res_attr   <= '0;
      res_addr   <= '0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_hit    <= nxt.hit;
      res_miss   <= !nxt.hit;
      res_win    <= nxt_idx;
      res_target <= nxt.tgt;
      res_attr   <= nxt.attr;
      res_addr   <= nxt.oaddr;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/xwm_checker.sv
module xwm_checker #(
  parameter int NUM_XLAT   = 8,
  parameter int HOLE_BYTES = 16,
  parameter int REG_AW     = 8,
  parameter int WIN_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic              res_miss,
  input logic [WIN_W-1:0]  res_win,
  input logic [3:0]        res_target,
  input logic [7:0]        res_attr,
  input logic [35:0]       res_addr
);
  localparam int LO_SPAN = NUM_XLAT * 16;
  localparam int HI_BASE = LO_SPAN + HOLE_BYTES;

  logic in_hole;
  assign in_hole = (int'(reg_addr) >= LO_SPAN) && (int'(reg_addr) < HI_BASE);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> res_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) &&
    $stable(res_win) && $stable(res_hit) && $stable(res_target) && $stable(res_attr));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !lk_ready);

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_miss |-> res_addr == '0 && res_win == '0 &&
    res_target == '0 && res_attr == '0);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_hit != res_miss);

  p_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_hole |-> reg_rdata == '0);
endmodule

bind xlat_window_map xwm_checker #(
  .NUM_XLAT(NUM_XLAT), .HOLE_BYTES(HOLE_BYTES), .REG_AW(REG_AW), .WIN_W(WIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_hit(res_hit), .res_miss(res_miss),
  .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
  .res_addr(res_addr)
);

// File: tb/xlat_window_map_bench.sv
module xlat_window_map_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [35:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit, res_miss;
  logic [4:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [35:0] res_addr;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  xlat_window_map u_xlat_window_map (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_miss(res_miss),
    .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
    .res_addr(res_addr)
  );

  typedef struct packed {
    logic [35:0] a;
    logic        hit;
    logic [4:0]  w;
    logic [3:0]  t;
    logic [7:0]  at;
    logic [35:0] o;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{36'h0_2000_0000, 1'b1, 5'd0,  4'h1, 8'h2E, 36'h0_8000_0000},
    '{36'h0_200F_FFFF, 1'b1, 5'd0,  4'h1, 8'h2E, 36'h0_800F_FFFF},
    '{36'h0_2010_0000, 1'b1, 5'd9,  4'h5, 8'h10, 36'h0_2010_0000},
    '{36'h0_200F_8000, 1'b1, 5'd0,  4'h1, 8'h2E, 36'h0_800F_8000},
    '{36'h0_2011_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},
    '{36'h0_1FFF_FFFF, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},
    '{36'h3_4000_0000, 1'b1, 5'd3,  4'h2, 8'h01, 36'h3_4000_0000},
    '{36'h3_4000_FFFF, 1'b1, 5'd3,  4'h2, 8'h01, 36'h3_4000_FFFF},
    '{36'h3_4001_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},
    '{36'h0_4000_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},
    '{36'hF_FFFF_FFFF, 1'b1, 5'd19, 4'hF, 8'hFF, 36'hF_FFFF_FFFF},
    '{36'h0_5000_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic lookup(input logic [35:0] a);
    @(negedge clk);
    res_ready = 1'b1; lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic res_check(input vec_t v, input string req);
    logic [63:0] act, exp;
    act = {res_valid, res_hit, res_miss, res_win, res_target, res_attr, res_addr};
    exp = {1'b1, v.hit, !v.hit, v.w, v.t, v.at, v.o};
    check(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    check(res_valid == 1'b0 && lk_ready == 1'b1, "R9 result idle",
          64'({res_valid, lk_ready}), 64'h1);
    rd_check(8'h00, 32'h0, "R9 ctrl w0");
    rd_check(8'h3C, 32'h0, "R9 remap hi w3");
    rd_check(8'h9C, 32'h0, "R9 base w9");
    lookup(36'h0_0000_0000);
    res_check('{36'h0, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0}, "R9 no hit after reset");

    // program windows (R1 R2 R6 R7)
    wr(8'h00, 32'h000F_2E11); wr(8'h04, 32'h2000_0000);
    wr(8'h08, 32'h8000_0000); wr(8'h0C, 32'h0000_0000);
    wr(8'h30, 32'h0000_0121); wr(8'h34, 32'h4000_0003);
    wr(8'h38, 32'h4000_0000); wr(8'h3C, 32'h0000_0003);
    wr(8'h50, 32'h000F_3320); wr(8'h54, 32'h5000_0000);
    wr(8'h98, 32'h0001_1051); wr(8'h9C, 32'h200F_0000);
    wr(8'hE8, 32'h0000_FFF1); wr(8'hEC, 32'hFFFF_000F);

    // R7: layout readback
    rd_check(8'h3C, 32'h0000_0003, "R7 remap hi w3 at 0x3C");
    rd_check(8'h98, 32'h0001_1051, "R7 ctrl w9 at 0x98");
    rd_check(8'hEC, 32'hFFFF_000F, "R7 base w19 at 0xEC");

    // R8: hole and out-of-range writes ignored
    wr(8'h80, 32'hFFFF_FFFF); wr(8'h8C, 32'hFFFF_FFFF); wr(8'hF0, 32'hFFFF_FFFF);
    rd_check(8'h80, 32'h0, "R8 hole reads zero");
    rd_check(8'hF0, 32'h0, "R8 past end reads zero");
    rd_check(8'h7C, 32'h0, "R8 w7 remap hi untouched");
    rd_check(8'h90, 32'h0, "R8 w8 ctrl untouched");

    // vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 12; i++) begin
      lookup(VECS[i].a);
      res_check(VECS[i], $sformatf("R1/R2/R3/R4/R5/R6 vec %0d", i));
    end

    // R10: back-pressure
    @(negedge clk); res_ready = 1'b1; lk_valid = 1'b0;
    @(negedge clk); res_ready = 1'b0; lk_valid = 1'b1; lk_addr = 36'h3_4000_0010;
    @(negedge clk); lk_addr = 36'hF_FFFF_FFFF;
    #1;
    check(res_valid && res_win == 5'd3 && !lk_ready, "R10 stall first result",
          64'({res_valid, res_win, lk_ready}), 64'({1'b1, 5'd3, 1'b0}));
    @(negedge clk);
    check(res_valid && res_win == 5'd3 && res_addr == 36'h3_4000_0010, "R10 held",
          64'(res_addr), 64'(36'h3_4000_0010));
    res_ready = 1'b1;
    @(negedge clk); lk_valid = 1'b0;
    check(res_valid && res_win == 5'd19, "R10 next after release",
          64'(res_win), 64'd19);

    // R11: clear window 0
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    rd_check(8'h08, 32'h0, "R11 remap lo cleared");
    lookup(36'h0_2000_0000);
    res_check('{36'h0, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0}, "R11 cleared window misses");
    lookup(36'h0_200F_8000);
    res_check('{36'h0, 1'b1, 5'd9, 4'h5, 8'h10, 36'h0_200F_8000}, "R11 falls to w9 (R4)");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule